// File: doc/BRIEF.md
# Multi-Mode Ladder Timer

This block is one timer of a ladder-logic controller. A two-bit mode input selects one of three behaviours. In on-delay mode, done asserts after the rung condition has been held long enough. In off-delay mode, done asserts once the rung condition has stayed low long enough after it fell. In retentive mode, the count survives while the rung is low, and only an explicit clear input removes it.

Time is measured in pulses of an external time-base tick. The accumulator advances by one on a tick while the active mode is timing, and it stops at the preset. The done bit is a register. The preset may be changed at run time. A preset of zero gives done with no delay.

Top module: `rung_timer`

## Requirements
- R1: In on-delay mode (mode 2'b00), while enable is high, each tick raises accum by one on that clock edge. A clock edge with enable low sets accum to zero.
- R2: In on-delay mode, done is 1 after the clock edge that follows the one where accum reached the preset. It stays 1 while enable is high. It drops to 0 on the first edge with enable low.
- R3: accum changes only by +1 on a clock edge with tick high, or to zero. It never increments past the preset.
- R4: In off-delay mode (mode 2'b01), an edge with enable high sets accum to zero. After a high-to-low change of enable, each tick raises accum by one for as long as enable stays low.
- R5: In off-delay mode, done becomes 1 on the edge after accum equals the preset while enable is low. It holds until the first edge with enable high, which clears it.
- R6: In retentive mode (mode 2'b10), accum counts ticks while enable is high. It keeps its value while enable is low, and counting resumes from that value.
- R7: In retentive mode, done becomes 1 on the edge after accum equals the preset with enable high. It then stays 1 whatever enable does, until an edge with clearIn high sets both done and accum to zero.
- R8: In on-delay and off-delay modes, clearIn has no effect on accum or done.
- R9: On any clock edge where mode differs from its value at the previous edge, accum and done are set to zero.
- R10: With a preset of zero, done becomes 1 on the first clock edge where the active mode's timing condition holds (enable high for on-delay, enable low after a fall for off-delay). No tick is needed.
- R11: Mode 2'b11 behaves exactly as on-delay.
- R12: An active-low asynchronous reset (rstN) clears accum and done at once. The mode history starts as on-delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00 on-delay, 01 off-delay, 10 retentive, 11 on-delay |
| enable | input | 1 | Rung condition |
| clearIn | input | 1 | Clear for retentive mode |
| tick | input | 1 | Time-base pulse, one clock wide |
| preset | input | W | Target count |
| accum | output | W | Accumulated ticks |
| done | output | 1 | Timer done bit |

## Verification
The hardest state to reach is retentive done held across a low rung with a partial count kept. Getting there needs the count to run up over several enable windows, then a cycle with enable high at the preset, and only then a low rung. The vector table builds that history step by step, as it does for the off-delay arming. The arming depends on a prior high level of enable, so each off-delay scenario first holds enable high for an edge and then drops it. Mode switches run between scenarios, so every scenario also checks the clear on a mode change.

// File: rtl/rung_timer_pkg.sv
package rung_timer_pkg;
  typedef enum logic [1:0] {
    MODE_ON     = 2'b00,
    MODE_OFF    = 2'b01,
    MODE_RET    = 2'b10,
    MODE_ON_ALT = 2'b11
  } timerMode_e;

  typedef struct packed {
    logic clear;
    logic step;
  } accStrobe_t;
endpackage

// File: rtl/rung_timer_dp.sv
module rung_timer_dp
  import rung_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  accStrobe_t   strobe,
  input  logic [W-1:0] preset,
  output logic [W-1:0] accum,
  output logic         atPreset
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              accum <= '0;
    else if (strobe.clear)  accum <= '0;
    else if (strobe.step)   accum <= accum + ONE;
  end

  assign atPreset = (accum >= preset);
endmodule

// File: rtl/rung_timer_ctrl.sv
module rung_timer_ctrl
  import rung_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       enable,
  input  logic       clearIn,
  input  logic       tick,
  input  logic       atPreset,
  output accStrobe_t strobe,
  output logic       done
);
  timerMode_e modeNow;
  logic [1:0] modePrev;
  logic       enablePrev;
  logic       armed;
  logic       armedNow;
  logic       armedNext;
  logic       modeChange;
  logic       doneNext;

  assign modeNow    = timerMode_e'(mode);
  assign modeChange = (mode != modePrev);
  assign armedNow   = !enable && (armed || enablePrev);
  assign armedNext  = !modeChange && armedNow;

  always_comb begin
    strobe   = '0;
    doneNext = done;
    if (modeChange) begin
      strobe.clear = 1'b1;
      doneNext     = 1'b0;
    end else begin
      unique case (modeNow)
        MODE_OFF: begin
          if (enable) begin
            strobe.clear = 1'b1;
            doneNext     = 1'b0;
          end else begin
            strobe.step = armedNow && tick && !atPreset;
            doneNext    = armedNow && atPreset;
          end
        end
        MODE_RET: begin
          if (clearIn) begin
            strobe.clear = 1'b1;
            doneNext     = 1'b0;
          end else begin
            strobe.step = enable && tick && !atPreset;
            doneNext    = done || (enable && atPreset);
          end
        end
        default: begin
          if (!enable) begin
            strobe.clear = 1'b1;
            doneNext     = 1'b0;
          end else begin
            strobe.step = tick && !atPreset;
            doneNext    = atPreset;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modePrev   <= MODE_ON;
      enablePrev <= 1'b0;
      armed      <= 1'b0;
      done       <= 1'b0;
    end else begin
      modePrev   <= mode;
      enablePrev <= enable;
      armed      <= armedNext;
      done       <= doneNext;
    end
  end
endmodule

// File: rtl/rung_timer.sv
module rung_timer
  import rung_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   mode,
  input  logic         enable,
  input  logic         clearIn,
  input  logic         tick,
  input  logic [W-1:0] preset,
  output logic [W-1:0] accum,
  output logic         done
);
  accStrobe_t strobe;
  logic       atPreset;

  rung_timer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mode     (mode),
    .enable   (enable),
    .clearIn  (clearIn),
    .tick     (tick),
    .atPreset (atPreset),
    .strobe   (strobe),
    .done     (done)
  );

  rung_timer_dp #(.W(W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .preset   (preset),
    .accum    (accum),
    .atPreset (atPreset)
  );
endmodule

// File: rtl/rung_timer_chk.sv
module rung_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic [1:0]   mode,
  input logic         enable,
  input logic         clearIn,
  input logic         tick,
  input logic [W-1:0] preset,
  input logic [W-1:0] accum,
  input logic         done
);
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accum != $past(accum) && accum != '0) |-> (accum == $past(accum) + W'(1) && $past(tick)));

  p_on_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && (mode == 2'b00 || mode == 2'b11)) |=> (accum == '0 && !done));

  p_off_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && mode == 2'b01) |=> (accum == '0 && !done));

  p_ret_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10 && $stable(mode) && !clearIn && !enable) |=> ($stable(accum) && $stable(done)));

  p_ret_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10 && clearIn) |=> (accum == '0 && !done));

  p_mode_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && mode != $past(mode)) |=> (accum == '0 && !done));
endmodule

bind rung_timer rung_timer_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .mode    (mode),
  .enable  (enable),
  .clearIn (clearIn),
  .tick    (tick),
  .preset  (preset),
  .accum   (accum),
  .done    (done)
);

// File: tb/sim_rung_timer.sv
`timescale 1ns/1ps
module sim_rung_timer;
  localparam int W = 8;
  localparam int NV = 40;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         enable = 1'b0;
  logic         clearIn = 1'b0;
  logic         tick = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] accum;
  logic         done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rung_timer #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .mode(mode), .enable(enable), .clearIn(clearIn),
    .tick(tick), .preset(preset), .accum(accum), .done(done)
  );

  // {mode, enable, clearIn, tick, preset, expected accum, expected done, requirement}
  localparam logic [25:0] VEC [NV] = '{
    {2'd0,1'b1,1'b0,1'b1,8'd3,8'd1,1'b0,4'd1},   // R1 count
    {2'd0,1'b1,1'b0,1'b0,8'd3,8'd1,1'b0,4'd1},   // R1 no tick
    {2'd0,1'b1,1'b0,1'b1,8'd3,8'd2,1'b0,4'd1},
    {2'd0,1'b0,1'b0,1'b1,8'd3,8'd0,1'b0,4'd1},   // R1 early drop
    {2'd0,1'b1,1'b0,1'b1,8'd3,8'd1,1'b0,4'd3},
    {2'd0,1'b1,1'b0,1'b1,8'd3,8'd2,1'b0,4'd3},
    {2'd0,1'b1,1'b0,1'b1,8'd3,8'd3,1'b0,4'd3},
    {2'd0,1'b1,1'b0,1'b1,8'd3,8'd3,1'b1,4'd3},   // R3 saturate
    {2'd0,1'b1,1'b0,1'b0,8'd3,8'd3,1'b1,4'd2},
    {2'd0,1'b0,1'b0,1'b0,8'd3,8'd0,1'b0,4'd2},   // R2 drop
    {2'd2,1'b0,1'b0,1'b0,8'd3,8'd0,1'b0,4'd9},   // R9
    {2'd2,1'b1,1'b0,1'b1,8'd3,8'd1,1'b0,4'd6},
    {2'd2,1'b0,1'b0,1'b1,8'd3,8'd1,1'b0,4'd6},   // R6 retain
    {2'd2,1'b1,1'b0,1'b1,8'd3,8'd2,1'b0,4'd6},
    {2'd2,1'b1,1'b0,1'b1,8'd3,8'd3,1'b0,4'd6},
    {2'd2,1'b1,1'b0,1'b0,8'd3,8'd3,1'b1,4'd7},
    {2'd2,1'b0,1'b0,1'b1,8'd3,8'd3,1'b1,4'd7},   // R7 hold
    {2'd2,1'b0,1'b1,1'b0,8'd3,8'd0,1'b0,4'd7},   // R7 clear
    {2'd1,1'b1,1'b0,1'b1,8'd3,8'd0,1'b0,4'd9},
    {2'd1,1'b1,1'b0,1'b1,8'd3,8'd0,1'b0,4'd4},
    {2'd1,1'b0,1'b0,1'b1,8'd3,8'd1,1'b0,4'd4},   // R4 fall
    {2'd1,1'b0,1'b0,1'b1,8'd3,8'd2,1'b0,4'd4},
    {2'd1,1'b0,1'b0,1'b0,8'd3,8'd2,1'b0,4'd4},
    {2'd1,1'b0,1'b0,1'b1,8'd3,8'd3,1'b0,4'd4},
    {2'd1,1'b0,1'b0,1'b0,8'd3,8'd3,1'b1,4'd5},
    {2'd1,1'b0,1'b1,1'b1,8'd3,8'd3,1'b1,4'd8},   // R8 off
    {2'd1,1'b1,1'b0,1'b0,8'd3,8'd0,1'b0,4'd5},
    {2'd0,1'b1,1'b0,1'b1,8'd3,8'd0,1'b0,4'd9},
    {2'd0,1'b1,1'b1,1'b1,8'd3,8'd1,1'b0,4'd8},   // R8 on
    {2'd0,1'b0,1'b0,1'b0,8'd0,8'd0,1'b0,4'd1},
    {2'd0,1'b1,1'b0,1'b1,8'd0,8'd0,1'b1,4'd10},  // R10 on
    {2'd0,1'b0,1'b0,1'b0,8'd0,8'd0,1'b0,4'd2},
    {2'd1,1'b1,1'b0,1'b0,8'd0,8'd0,1'b0,4'd9},
    {2'd1,1'b0,1'b0,1'b0,8'd0,8'd0,1'b1,4'd10},  // R10 off
    {2'd1,1'b1,1'b0,1'b0,8'd0,8'd0,1'b0,4'd5},
    {2'd3,1'b1,1'b0,1'b1,8'd2,8'd0,1'b0,4'd9},
    {2'd3,1'b1,1'b0,1'b1,8'd2,8'd1,1'b0,4'd11},  // R11
    {2'd3,1'b1,1'b0,1'b1,8'd2,8'd2,1'b0,4'd11},
    {2'd3,1'b1,1'b0,1'b0,8'd2,8'd2,1'b1,4'd11},
    {2'd2,1'b1,1'b0,1'b1,8'd2,8'd0,1'b0,4'd9}
  };

  function automatic string reqName(input logic [3:0] id);
    case (id)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic checkOut(input string req, input logic [W-1:0] expAcc, input logic expDone);
    checks++;
    if (accum !== expAcc || done !== expDone) begin
      errors++;
      $display("FAIL %s: accum=%0d done=%0b expected accum=%0d done=%0b",
               req, accum, done, expAcc, expDone);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R12", '0, 1'b0);          // reset state
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      mode    = VEC[i][25:24];
      enable  = VEC[i][23];
      clearIn = VEC[i][22];
      tick    = VEC[i][21];
      preset  = VEC[i][20:13];
      @(negedge clk);
      checkOut(reqName(VEC[i][3:0]), VEC[i][12:5], VEC[i][4]);
    end
    // Directed: build a count in on-delay, then reset asynchronously (R12)
    mode = 2'b00; enable = 1'b1; tick = 1'b1; clearIn = 1'b0; preset = 8'd5;
    @(negedge clk);
    checkOut("R9", '0, 1'b0);
    repeat (2) @(negedge clk);
    checkOut("R1", 8'd2, 1'b0);
    #2 rstN = 1'b0;
    #1 checkOut("R12", '0, 1'b0);
    @(negedge clk);
    checkOut("R12", '0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1", 8'd1, 1'b0);
    finishRun();
  end
endmodule